// File: doc/BRIEF.md
# Packed Byte-Lane Shift Unit

This unit splits an XLEN-wide source operand into XLEN/8 independent 8-bit lanes and shifts every lane by one common amount. The amount comes either from the low bits of a second source operand or from a 3-bit field inside the instruction word. The unit decodes the instruction word itself. It offers several shift kinds: plain arithmetic and logical right shifts, a left shift that wraps, right shifts that round, a left shift that saturates, and a shift whose direction is taken from the sign of a 4-bit amount.

Each accepted operation is captured in one register stage. The packed result and a one-cycle saturation pulse appear on the cycle after `in_valid`. The pulse is the OR of all lane overflows. A surrounding pipeline keeps the sticky copy of that flag.

Top module: `pbs_shifter`

## Requirements
- R1: With opcode bits [6:0]=1111111 and funct3 [14:12]=000, funct7 [31:25]=0101100 shifts each 8-bit lane of `rs1` right by `rs2[2:0]`, filling with copies of that lane's bit 7. Lanes do not interact.
- R2: funct7 0101101 shifts each lane right by `rs2[2:0]` and fills with zeros.
- R3: funct7 0101110 shifts each lane left by `rs2[2:0]`. Bits that leave the lane are dropped, and `sat` stays 0.
- R4: funct7 0110100 (signed) and 0110101 (unsigned) shift right by s=`rs2[2:0]` with round-half-up. The result is floor((lane + 2^(s-1)) / 2^s). When s=0 the lane passes through unchanged.
- R5: funct7 0110110 shifts each signed lane left by `rs2[2:0]`. If the true product does not fit in -128..127, that lane becomes 0x80 (negative input) or 0x7F (otherwise), and `sat` is 1.
- R6: funct7 0101111 reads `rs2[3:0]` as a two's-complement amount a in -8..7. For a>=0 it behaves as R5 with amount a. For a<0 it shifts arithmetically right by |a|, with a magnitude of 8 reduced to 7.
- R7: funct7 0110111 behaves as R6, except that negative amounts use the signed rounding right shift of R4.
- R8: Immediate forms use funct7 0111100 (arithmetic right), 0111101 (logical right) and 0111110 (left). Bits [24:23]=00 select the plain form and 01 select the rounding form (for left, the saturating form). The amount is instruction bits [22:20], and `rs2` has no effect.
- R9: `sat` is the OR of all lane overflows. It can be 1 only together with `out_valid`, and only for the operations of R5 to R8 that saturate. It is 0 for every other operation.
- R10: A word with a different opcode or funct3, an unknown funct7, or immediate bits [24:23] of 1x is not accepted, and `out_valid` stays 0 on the next cycle.
- R11: An accepted operation gives `out_valid`, `result` and `sat` on the cycle after `in_valid`. A synchronous reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| rs1 | input | XLEN | Packed source lanes |
| rs2 | input | XLEN | Amount operand (low 4 bits used) |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Packed shifted lanes |
| sat | output | 1 | Saturation pulse, OR over lanes |

## Verification
The bench builds the unit with XLEN=64, which gives eight lanes. That width lets one operand mix positive, negative, boundary (0x7F, 0x80, 0xFF) and odd-rounding values in the upper and lower words at the same time, so a lane-indexing or carry-between-lanes fault shows up. Every amount from 0 to 7 is swept for each shift kind. The signed-direction forms are swept over all sixteen 4-bit amounts, which reaches the -8 clamp. XLEN=32 elaborates the same generate loop with four lanes.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANE_W = 8;

    localparam logic [6:0] OPC_PACKED = 7'b1111111;
    localparam logic [2:0] F3_SHIFT   = 3'b000;

    localparam logic [6:0] F7_SRA     = 7'b0101100;
    localparam logic [6:0] F7_SRA_RND = 7'b0110100;
    localparam logic [6:0] F7_SRL     = 7'b0101101;
    localparam logic [6:0] F7_SRL_RND = 7'b0110101;
    localparam logic [6:0] F7_SLL     = 7'b0101110;
    localparam logic [6:0] F7_SLL_SAT = 7'b0110110;
    localparam logic [6:0] F7_DIR     = 7'b0101111;
    localparam logic [6:0] F7_DIR_RND = 7'b0110111;
    localparam logic [6:0] F7_IMM_SRA = 7'b0111100;
    localparam logic [6:0] F7_IMM_SRL = 7'b0111101;
    localparam logic [6:0] F7_IMM_SLL = 7'b0111110;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SRA,
        OP_SRA_RND,
        OP_SRL,
        OP_SRL_RND,
        OP_SLL,
        OP_SLL_SAT,
        OP_DIR,
        OP_DIR_RND
    } shop_e;

    typedef struct packed {
        logic  legal;
        logic  use_imm;
        shop_e op;
    } shctl_t;

    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic              ovf;
    } lane_res_t;

    // Right shift of one lane, optionally rounded half-up.
    function automatic logic [LANE_W-1:0] f_rshift(
        input logic [LANE_W-1:0] a,
        input logic [2:0]        s,
        input logic              arith,
        input logic              rnd
    );
        logic signed [LANE_W+1:0] ext;
        logic signed [LANE_W+1:0] t;
        ext = {{2{arith & a[LANE_W-1]}}, a};
        if (!rnd || s == 3'd0) begin
            t = ext >>> s;
            return t[LANE_W-1:0];
        end
        t = (ext >>> (s - 3'd1)) + 10'sd1;
        return t[LANE_W:1];
    endfunction

    // Signed left shift that clamps each lane to its range.
    function automatic lane_res_t f_sat_lshift(
        input logic [LANE_W-1:0] a,
        input logic [2:0]        s
    );
        logic [2*LANE_W-1:0] wide;
        lane_res_t           r;
        wide  = {{LANE_W{a[LANE_W-1]}}, a} << s;
        r.ovf = (wide[2*LANE_W-1:LANE_W-1] != {(LANE_W+1){wide[LANE_W-1]}});
        if (r.ovf)
            r.val = a[LANE_W-1] ? 8'h80 : 8'h7F;
        else
            r.val = wide[LANE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
    import pbs_pkg::*;
(
    input  logic [31:0] insn,
    output shctl_t      ctl
);
    logic [6:0] f7;
    logic [1:0] sel;
    logic       base_ok;

    assign f7      = insn[31:25];
    assign sel     = insn[24:23];
    assign base_ok = (insn[6:0] == OPC_PACKED) && (insn[14:12] == F3_SHIFT);

    always_comb begin
        ctl = '{legal: 1'b0, use_imm: 1'b0, op: OP_NONE};
        if (base_ok) begin
            ctl.legal = 1'b1;
            unique case (f7)
                F7_SRA:     ctl.op = OP_SRA;
                F7_SRA_RND: ctl.op = OP_SRA_RND;
                F7_SRL:     ctl.op = OP_SRL;
                F7_SRL_RND: ctl.op = OP_SRL_RND;
                F7_SLL:     ctl.op = OP_SLL;
                F7_SLL_SAT: ctl.op = OP_SLL_SAT;
                F7_DIR:     ctl.op = OP_DIR;
                F7_DIR_RND: ctl.op = OP_DIR_RND;
                F7_IMM_SRA: begin
                    ctl.use_imm = 1'b1;
                    ctl.op      = sel[0] ? OP_SRA_RND : OP_SRA;
                    ctl.legal   = !sel[1];
                end
                F7_IMM_SRL: begin
                    ctl.use_imm = 1'b1;
                    ctl.op      = sel[0] ? OP_SRL_RND : OP_SRL;
                    ctl.legal   = !sel[1];
                end
                F7_IMM_SLL: begin
                    ctl.use_imm = 1'b1;
                    ctl.op      = sel[0] ? OP_SLL_SAT : OP_SLL;
                    ctl.legal   = !sel[1];
                end
                default: ctl.legal = 1'b0;
            endcase
            if (!ctl.legal) ctl.op = OP_NONE;
        end
    end

    // R10: a word that is not accepted never carries an operation
    always_comb begin
        if (ctl.legal == 1'b0)
            a_r10_no_op_when_illegal: assert (ctl.op == OP_NONE)
                else $error("illegal word decoded to an operation");
    end
endmodule

// File: rtl/pbs_lane.sv
module pbs_lane
    import pbs_pkg::*;
(
    input  shop_e              op,
    input  logic [3:0]         amt,
    input  logic [LANE_W-1:0]  din,
    output logic [LANE_W-1:0]  dout,
    output logic               ovf
);
    logic [2:0] s3;
    logic [3:0] mag;
    logic [2:0] rmag;
    lane_res_t  satr;

    assign s3   = amt[2:0];
    assign mag  = (~amt) + 4'd1;
    assign rmag = mag[3] ? 3'd7 : mag[2:0];

    always_comb begin
        dout = '0;
        ovf  = 1'b0;
        satr = f_sat_lshift(din, s3);
        unique case (op)
            OP_SRA:     dout = f_rshift(din, s3, 1'b1, 1'b0);
            OP_SRL:     dout = f_rshift(din, s3, 1'b0, 1'b0);
            OP_SRA_RND: dout = f_rshift(din, s3, 1'b1, 1'b1);
            OP_SRL_RND: dout = f_rshift(din, s3, 1'b0, 1'b1);
            OP_SLL:     dout = din << s3;
            OP_SLL_SAT: begin
                dout = satr.val;
                ovf  = satr.ovf;
            end
            OP_DIR, OP_DIR_RND: begin
                if (!amt[3]) begin
                    dout = satr.val;
                    ovf  = satr.ovf;
                end else begin
                    dout = f_rshift(din, rmag, 1'b1, op == OP_DIR_RND);
                end
            end
            default: dout = '0;
        endcase
    end

    // R5: an overflowing lane holds one of the two clamp values
    always_comb begin
        if (ovf == 1'b1)
            a_r5_clamp_value: assert (dout == 8'h80 || dout == 8'h7F)
                else $error("saturated lane not clamped");
    end

    // R1: sign-filling right shift keeps the lane sign
    always_comb begin
        if (op == OP_SRA)
            a_r1_sign_kept: assert (dout[LANE_W-1] == din[LANE_W-1])
                else $error("arithmetic shift lost sign");
    end
endmodule

// File: rtl/pbs_shifter.sv
module pbs_shifter
    import pbs_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            sat
);
    localparam int NLANES = XLEN / LANE_W;

    shctl_t            ctl;
    logic [3:0]        amt;
    logic [XLEN-1:0]   res_w;
    logic [NLANES-1:0] lane_ovf;
    shop_e             op_q;

    pbs_decode u_dec (.insn(insn), .ctl(ctl));

    assign amt = ctl.use_imm ? {1'b0, insn[22:20]} : rs2[3:0];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        pbs_lane u_lane (
            .op  (ctl.op),
            .amt (amt),
            .din (rs1[g*LANE_W +: LANE_W]),
            .dout(res_w[g*LANE_W +: LANE_W]),
            .ovf (lane_ovf[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            sat       <= 1'b0;
            op_q      <= OP_NONE;
        end else begin
            out_valid <= in_valid && ctl.legal;
            op_q      <= ctl.op;
            if (in_valid && ctl.legal) begin
                result <= res_w;
                sat    <= |lane_ovf;
            end else begin
                sat    <= 1'b0;
            end
        end
    end

    a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.legal) |=> out_valid)
        else $error("accepted word gave no result");

    a_r10_illegal_dropped: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.legal) |=> !out_valid)
        else $error("rejected word gave a result");

    a_r9_sat_is_pulse: assert property (@(posedge clk) disable iff (rst)
        sat |-> out_valid)
        else $error("saturation without result");

    a_r9_sat_only_sat_ops: assert property (@(posedge clk) disable iff (rst)
        sat |-> (op_q == OP_SLL_SAT || op_q == OP_DIR || op_q == OP_DIR_RND))
        else $error("saturation from a non-saturating op");
endmodule

// File: tb/pbs_shifter_bench.sv
module pbs_shifter_bench;
    localparam int XLEN = 64;
    localparam int NL   = XLEN / 8;

    typedef struct {
        logic [XLEN-1:0] res;
        logic            sat;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [XLEN-1:0] rs1 = '0;
    logic [XLEN-1:0] rs2 = '0;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic            sat;

    int   errors = 0;
    int   checks = 0;
    bit   done   = 0;
    exp_t q[$];

    pbs_shifter #(.XLEN(XLEN)) u_pbs_shifter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .rs1(rs1), .rs2(rs2), .out_valid(out_valid), .result(result), .sat(sat)
    );

    always #5 clk = ~clk;

    // bench mode codes: 0 sra 1 srl 2 sll 3 sra-rnd 4 srl-rnd 5 sat-left 6 dir 7 dir-rnd
    function automatic int m_rnd(int x, int s);
        if (s == 0) return x;
        return (x + (1 << (s - 1))) >>> s;
    endfunction

    function automatic void m_sat(int x, int s, output int v, output bit o);
        int p;
        p = x * (1 << s);
        o = 1'b0;
        v = p;
        if (p > 127)  begin v = 127;  o = 1'b1; end
        if (p < -128) begin v = -128; o = 1'b1; end
    endfunction

    function automatic exp_t model(int mode, logic [XLEN-1:0] a, int amt4, string tag);
        exp_t e;
        e.res = '0; e.sat = 1'b0; e.tag = tag;
        for (int l = 0; l < NL; l++) begin
            int  u, x, s3, sa, v, m;
            bit  o;
            u  = int'(a[l*8 +: 8]);
            x  = (u > 127) ? u - 256 : u;
            s3 = amt4 & 7;
            sa = (amt4 > 7) ? amt4 - 16 : amt4;
            o  = 1'b0;
            case (mode)
                0: v = x >>> s3;
                1: v = u >> s3;
                2: v = u << s3;
                3: v = m_rnd(x, s3);
                4: v = m_rnd(u, s3);
                5: m_sat(x, s3, v, o);
                default: begin
                    if (sa >= 0) m_sat(x, sa, v, o);
                    else begin
                        m = -sa;
                        if (m == 8) m = 7;
                        v = (mode == 7) ? m_rnd(x, m) : (x >>> m);
                    end
                end
            endcase
            e.res[l*8 +: 8] = v[7:0];
            e.sat = e.sat | o;
        end
        return e;
    endfunction

    function automatic logic [31:0] rword(logic [6:0] f7);
        return {f7, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1111111};
    endfunction

    function automatic logic [31:0] iword(logic [6:0] f7, logic [1:0] sel, logic [2:0] sh);
        return {f7, sel, sh, 5'd1, 3'b000, 5'd3, 7'b1111111};
    endfunction

    task automatic send(logic [31:0] w, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                        int mode, int amt4, string tag);
        @(posedge clk); #2;
        in_valid = 1'b1; insn = w; rs1 = a; rs2 = b;
        q.push_back(model(mode, a, amt4, tag));
    endtask

    task automatic send_bad(logic [31:0] w, string tag);
        @(posedge clk); #2;
        in_valid = 1'b1; insn = w; rs1 = 64'hFFFF_0000_8080_7F7F; rs2 = 64'h3;
        @(negedge clk);
        // the scoreboard monitor pops the previous item at this edge; drain it first
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: out_valid=%b expected 0", tag, out_valid);
        end
    endtask

    task automatic idle();
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    // monitor: compares every produced result against the queue front
    always @(negedge clk) begin
        if (!rst && out_valid === 1'b1) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R10/R11: unexpected result %h, expected none", result);
            end else begin
                e = q.pop_front();
                if (result !== e.res || sat !== e.sat) begin
                    errors++;
                    $display("FAIL %s: result=%h sat=%b expected result=%h sat=%b",
                             e.tag, result, sat, e.res, e.sat);
                end
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [XLEN-1:0] PAT_A = 64'h807F_01FF_40C0_55AA;
    localparam logic [XLEN-1:0] PAT_B = 64'h0305_0B0D_F3FB_8177;
    localparam logic [XLEN-1:0] PAT_C = 64'h1F20_E0DF_0F10_F0EF;

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || sat !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: v=%b r=%h s=%b expected 0/0/0", out_valid, result, sat);
        end
        rst = 1'b0;

        for (int s = 0; s < 8; s++) begin
            send(rword(7'b0101100), PAT_A, XLEN'(s) | 64'hF0, 0, s, "R1 sra");
            send(rword(7'b0101101), PAT_A, XLEN'(s), 1, s, "R2 srl");
            send(rword(7'b0101110), PAT_B, XLEN'(s), 2, s, "R3 sll");
            send(rword(7'b0110100), PAT_B, XLEN'(s), 3, s, "R4 sra-round");
            send(rword(7'b0110101), PAT_A, XLEN'(s), 4, s, "R4 srl-round");
            send(rword(7'b0110110), PAT_C, XLEN'(s), 5, s, "R5 sat-left");
            send(rword(7'b0110110), PAT_A, XLEN'(s), 5, s, "R5 sat-left boundaries");
        end
        for (int a = 0; a < 16; a++) begin
            send(rword(7'b0101111), PAT_A, XLEN'(a), 6, a, "R6 signed-direction");
            send(rword(7'b0101111), PAT_C, XLEN'(a), 6, a, "R6 signed-direction");
            send(rword(7'b0110111), PAT_B, XLEN'(a), 7, a, "R7 signed-direction round");
        end
        for (int s = 0; s < 8; s++) begin
            send(iword(7'b0111100, 2'b00, 3'(s)), PAT_A, 64'h7, 0, s, "R8 imm sra");
            send(iword(7'b0111100, 2'b01, 3'(s)), PAT_B, 64'h5, 3, s, "R8 imm sra-round");
            send(iword(7'b0111101, 2'b00, 3'(s)), PAT_A, 64'h6, 1, s, "R8 imm srl");
            send(iword(7'b0111101, 2'b01, 3'(s)), PAT_A, 64'h1, 4, s, "R8 imm srl-round");
            send(iword(7'b0111110, 2'b00, 3'(s)), PAT_C, 64'h0, 2, s, "R8 imm sll");
            send(iword(7'b0111110, 2'b01, 3'(s)), PAT_C, 64'h2, 5, s, "R8 imm sat-left");
        end
        // R9: heavy overflow input through a non-saturating left shift keeps sat at 0
        send(rword(7'b0101110), 64'h7F7F_8080_4040_C0C0, 64'h7, 2, 7, "R9 no sat on plain left");
        send(rword(7'b0110110), 64'h0000_0000_0000_0040, 64'h1, 5, 1, "R9 single lane sat");
        idle();

        // R10: rejected encodings
        send_bad({7'b0101100, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, "R10 wrong opcode");
        send_bad({7'b0101100, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1111111}, "R10 wrong funct3");
        send_bad(iword(7'b0111100, 2'b10, 3'd2), "R10 imm select 10");
        send_bad(iword(7'b0111110, 2'b11, 3'd1), "R10 imm select 11");
        send_bad(rword(7'b0000001), "R10 unknown funct7");

        repeat (4) @(posedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d results missing, expected 0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule